// File: doc/BRIEF.md
# Pulse Period Jitter Monitor

This block watches one pulse-frequency output line and measures how regular its pulses are. Every falling edge of the resynchronised input closes one period and opens the next. Periods are counted in system clocks with no gap between them. The periods are grouped into back-to-back windows of four. For each window the block reports the longest period, the shortest period, the mean period and a jitter figure. The jitter figure is the spread between the longest and shortest period, taken as a percentage of the mean.

The jitter value is a fixed-point percentage with `FRAC_W` fractional bits. A serial divider produces it after the window closes, and a one-cycle strobe marks each new set of results. The block suits production test and in-field self-check of a pulse output. The enable input stops measurement, and the clear input throws away whatever window is in progress.

Top module: `pulse_jitter_monitor`

## Requirements
- R1: A period is the number of clock cycles between two consecutive falling edges of `pulseIn`, seen after a two-flop synchroniser. Periods are measured back to back. The first falling edge after reset, after `enable` rises, or after `clear` only starts timing and yields no period.
- R2: Each result covers exactly four consecutive periods. Windows do not overlap: the edge that closes the fourth period also opens the first period of the next window.
- R3: `maxPeriod` is the largest of the window's four periods and `minPeriod` is the smallest.
- R4: `avgPeriod` is the sum of the four periods shifted right by two, so any remainder is dropped.
- R5: `jitterPct` equals floor((max − min) × 100 × 2^FRAC_W / avg). This is a percentage with FRAC_W fractional bits. A value too large for JIT_W bits is reported as all ones.
- R6: `resultValid` is high for exactly one cycle per result. All four result outputs take their new values in that same cycle and stay unchanged until the next strobe.
- R7: The period counter saturates at all ones (2^CNT_W − 1) instead of wrapping. A window containing a period that reached all ones produces no result.
- R8: While `clear` is high, the partial window, the period count and any division in progress are discarded. The first falling edge afterwards only starts timing.
- R9: While `enable` is low, falling edges produce no periods and the partial window is discarded.
- R10: A window that closes while the division for the previous window is still running produces no result.
- R11: After reset, all result outputs are zero and `resultValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Measurement enable, synchronous |
| clear | input | 1 | Synchronous discard of partial window, count and division |
| pulseIn | input | 1 | Asynchronous pulse line under test |
| maxPeriod | output | CNT_W | Longest period of the last reported window |
| minPeriod | output | CNT_W | Shortest period of the last reported window |
| avgPeriod | output | CNT_W | Mean period (sum / 4, truncated) |
| jitterPct | output | JIT_W | Peak-to-peak jitter in percent, FRAC_W fractional bits |
| resultValid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench streams pulse trains with equal periods, uneven periods, and sums that are not divisible by four. Equal periods must give zero jitter. An uneven sum shows whether the mean is truncated or rounded. A design off by one edge in its windowing would pair the wrong periods, and every later result would mismatch. A very spread window drives the jitter past the output width; a design without clamping would return the wrapped low bits instead of all ones. The bench also includes:
- one over-long period, to check the block drops that window instead of reporting a wrapped count;
- a burst of short periods that closes during a division, where a design would otherwise corrupt or duplicate a result;
- clear and enable-low events in mid-window, which a design that kept stale periods would fold into the next result.

// File: rtl/pjm_pkg.sv
package pjm_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic restartCnt;  // falling edge: period counter restarts at 1
    logic takePeriod;  // a measured period enters the window statistics
    logic firstOfWin;  // the taken period is period 0 of a window
    logic loadDiv;     // window closed cleanly: latch stats, start divide
    logic divStep;     // one restoring-division iteration
    logic publish;     // copy held results to the outputs
    logic flush;       // discard count and partial window
  } pjm_ctrl_t;

  typedef enum logic [1:0] {
    DIV_IDLE = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_FIN  = 2'd2
  } div_state_e;

endpackage

// File: rtl/pjm_ctrl.sv
module pjm_ctrl
  import pjm_pkg::*;
#(
  parameter int NUM_W = 39
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      clear,
  input  logic      pulseIn,
  input  logic      windowSat,
  output pjm_ctrl_t ctrl
);

  localparam int STEP_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

  logic syncA, syncB, prevB;
  logic armed;
  logic [1:0] winIdx;
  div_state_e divState;
  logic [STEP_W-1:0] stepCnt;

  logic fallEdge, runOk, lastTake;

  // Two-flop synchroniser plus one stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= pulseIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign fallEdge = prevB & ~syncB;
  assign runOk    = enable & ~clear;
  assign lastTake = ctrl.takePeriod & (winIdx == 2'd3);

  always_comb begin
    ctrl            = '0;
    ctrl.flush      = clear;
    ctrl.restartCnt = runOk & fallEdge;
    ctrl.takePeriod = runOk & fallEdge & armed;
    ctrl.firstOfWin = (winIdx == 2'd0);
    ctrl.loadDiv    = lastTake & ~windowSat & (divState == DIV_IDLE);
    ctrl.divStep    = (divState == DIV_RUN) & ~clear;
    ctrl.publish    = (divState == DIV_FIN) & ~clear;
  end

  // Arming and window position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      winIdx <= 2'd0;
    end else if (!runOk) begin
      armed  <= 1'b0;
      winIdx <= 2'd0;
    end else if (fallEdge) begin
      armed <= 1'b1;
      if (armed) winIdx <= winIdx + 2'd1;
    end
  end

  // Division sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divState <= DIV_IDLE;
      stepCnt  <= '0;
    end else if (clear) begin
      divState <= DIV_IDLE;
      stepCnt  <= '0;
    end else begin
      unique case (divState)
        DIV_IDLE: if (ctrl.loadDiv) begin
          divState <= DIV_RUN;
          stepCnt  <= STEP_W'(NUM_W - 1);
        end
        DIV_RUN: begin
          if (stepCnt == '0) divState <= DIV_FIN;
          else               stepCnt  <= stepCnt - 1'b1;
        end
        DIV_FIN:  divState <= DIV_IDLE;
        default:  divState <= DIV_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pjm_datapath.sv
module pjm_datapath
  import pjm_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int FRAC_W = 8,
  parameter int JIT_W  = 20,
  parameter int NUM_W  = 39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pjm_ctrl_t        ctrl,
  output logic             windowSat,
  output logic [CNT_W-1:0] maxPeriod,
  output logic [CNT_W-1:0] minPeriod,
  output logic [CNT_W-1:0] avgPeriod,
  output logic [JIT_W-1:0] jitterPct,
  output logic             resultValid
);

  localparam int SCALE = 100 * (2 ** FRAC_W);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] winMax, winMin;
  logic [SUM_W-1:0] winSum;
  logic             winSat;

  logic [CNT_W-1:0] holdMax, holdMin, holdAvg;
  logic [NUM_W-1:0] numQ;
  logic [CNT_W-1:0] remR;

  logic             curSat;
  logic [CNT_W-1:0] nxtMax, nxtMin, spread;
  logic [SUM_W-1:0] nxtSum;
  logic [CNT_W:0]   trial, trialDiff;
  logic             trialGe;
  logic [JIT_W-1:0] jitNext;

  // Saturating period counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               periodCnt <= '0;
    else if (ctrl.flush)      periodCnt <= '0;
    else if (ctrl.restartCnt) periodCnt <= CNT_W'(1);
    else if (periodCnt != CNT_MAX) periodCnt <= periodCnt + 1'b1;
  end

  assign curSat = (periodCnt == CNT_MAX);

  // Folded window statistics including the period being taken now
  always_comb begin
    if (ctrl.firstOfWin) begin
      nxtMax = periodCnt;
      nxtMin = periodCnt;
      nxtSum = SUM_W'(periodCnt);
    end else begin
      nxtMax = (periodCnt > winMax) ? periodCnt : winMax;
      nxtMin = (periodCnt < winMin) ? periodCnt : winMin;
      nxtSum = winSum + SUM_W'(periodCnt);
    end
  end

  assign windowSat = winSat | curSat;
  assign spread    = nxtMax - nxtMin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winMax <= '0;
      winMin <= '0;
      winSum <= '0;
      winSat <= 1'b0;
    end else if (ctrl.flush) begin
      winMax <= '0;
      winMin <= '0;
      winSum <= '0;
      winSat <= 1'b0;
    end else if (ctrl.takePeriod) begin
      winMax <= nxtMax;
      winMin <= nxtMin;
      winSum <= nxtSum;
      winSat <= ctrl.firstOfWin ? curSat : (winSat | curSat);
    end
  end

  // Restoring divider: one quotient bit per step, quotient shifts into numQ
  assign trial     = {remR, numQ[NUM_W-1]};
  assign trialGe   = (trial >= {1'b0, holdAvg});
  assign trialDiff = trial - {1'b0, holdAvg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdMax <= '0;
      holdMin <= '0;
      holdAvg <= '0;
      numQ    <= '0;
      remR    <= '0;
    end else if (ctrl.loadDiv) begin
      holdMax <= nxtMax;
      holdMin <= nxtMin;
      holdAvg <= nxtSum[SUM_W-1:2];
      numQ    <= NUM_W'(spread) * NUM_W'(SCALE);
      remR    <= '0;
    end else if (ctrl.divStep) begin
      remR <= trialGe ? trialDiff[CNT_W-1:0] : trial[CNT_W-1:0];
      numQ <= {numQ[NUM_W-2:0], trialGe};
    end
  end

  generate
    if (NUM_W > JIT_W) begin : g_clamp
      assign jitNext = (|numQ[NUM_W-1:JIT_W]) ? '1 : numQ[JIT_W-1:0];
    end else begin : g_extend
      assign jitNext = JIT_W'(numQ);
    end
  endgenerate

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maxPeriod   <= '0;
      minPeriod   <= '0;
      avgPeriod   <= '0;
      jitterPct   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctrl.publish;
      if (ctrl.publish) begin
        maxPeriod <= holdMax;
        minPeriod <= holdMin;
        avgPeriod <= holdAvg;
        jitterPct <= jitNext;
      end
    end
  end

endmodule

// File: rtl/pulse_jitter_monitor.sv
module pulse_jitter_monitor
  import pjm_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int FRAC_W = 8,
  parameter int JIT_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clear,
  input  logic             pulseIn,
  output logic [CNT_W-1:0] maxPeriod,
  output logic [CNT_W-1:0] minPeriod,
  output logic [CNT_W-1:0] avgPeriod,
  output logic [JIT_W-1:0] jitterPct,
  output logic             resultValid
);

  localparam int SCALE   = 100 * (2 ** FRAC_W);
  localparam int SCALE_W = $clog2(SCALE + 1);
  localparam int NUM_W   = CNT_W + SCALE_W;

  pjm_ctrl_t ctrl;
  logic      windowSat;

  pjm_ctrl #(
    .NUM_W(NUM_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .clear    (clear),
    .pulseIn  (pulseIn),
    .windowSat(windowSat),
    .ctrl     (ctrl)
  );

  pjm_datapath #(
    .CNT_W (CNT_W),
    .FRAC_W(FRAC_W),
    .JIT_W (JIT_W),
    .NUM_W (NUM_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .windowSat  (windowSat),
    .maxPeriod  (maxPeriod),
    .minPeriod  (minPeriod),
    .avgPeriod  (avgPeriod),
    .jitterPct  (jitterPct),
    .resultValid(resultValid)
  );

endmodule

// File: rtl/pulse_jitter_checker.sv
module pulse_jitter_checker #(
  parameter int CNT_W = 24,
  parameter int JIT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic [CNT_W-1:0] maxPeriod,
  input logic [CNT_W-1:0] minPeriod,
  input logic [CNT_W-1:0] avgPeriod,
  input logic [JIT_W-1:0] jitterPct,
  input logic             resultValid
);

  // R6: strobe lasts one cycle
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  // R6: outputs only change together with the strobe
  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !resultValid |-> ($stable(maxPeriod) && $stable(minPeriod) &&
                      $stable(avgPeriod) && $stable(jitterPct)));

  // R3: ordering of extremes in a reported window
  p_min_le_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> (minPeriod <= maxPeriod));

  // R4: mean lies between the extremes
  p_avg_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> (avgPeriod >= minPeriod && avgPeriod <= maxPeriod));

  // R7: a saturated period never reaches the outputs
  p_no_sat_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> (maxPeriod != '1));

  // R8: clear suppresses the next strobe
  p_clear_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !resultValid);

endmodule

bind pulse_jitter_monitor pulse_jitter_checker #(
  .CNT_W(CNT_W),
  .JIT_W(JIT_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .maxPeriod  (maxPeriod),
  .minPeriod  (minPeriod),
  .avgPeriod  (avgPeriod),
  .jitterPct  (jitterPct),
  .resultValid(resultValid)
);

// File: tb/pulse_jitter_monitor_tb.sv
module pulse_jitter_monitor_tb;

  localparam int CNT_W  = 10;
  localparam int FRAC_W = 8;
  localparam int JIT_W  = 16;
  localparam int SAT_V  = (1 << CNT_W) - 1;
  localparam longint JIT_MAX = (64'd1 << JIT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic clear = 1'b0;
  logic pulseIn = 1'b1;
  logic [CNT_W-1:0] maxPeriod, minPeriod, avgPeriod;
  logic [JIT_W-1:0] jitterPct;
  logic resultValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int     mx;
    int     mn;
    int     av;
    longint jt;
  } exp_t;

  exp_t expQ[$];
  int   winBuf[$];
  int   skipWindows = 0;

  always #4 clk = ~clk;

  pulse_jitter_monitor #(
    .CNT_W (CNT_W),
    .FRAC_W(FRAC_W),
    .JIT_W (JIT_W)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .clear      (clear),
    .pulseIn    (pulseIn),
    .maxPeriod  (maxPeriod),
    .minPeriod  (minPeriod),
    .avgPeriod  (avgPeriod),
    .jitterPct  (jitterPct),
    .resultValid(resultValid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: one period per call; the falling edge is at the call's start
  task automatic sendPeriod(input int p);
    int h;
    winBuf.push_back(p);
    if (winBuf.size() == 4) begin
      exp_t e;
      int   sum;
      bit   sat;
      e.mx = winBuf[0]; e.mn = winBuf[0]; sum = 0; sat = 1'b0;
      foreach (winBuf[i]) begin
        if (winBuf[i] > e.mx) e.mx = winBuf[i];
        if (winBuf[i] < e.mn) e.mn = winBuf[i];
        sum += winBuf[i];
        if (winBuf[i] >= SAT_V) sat = 1'b1;
      end
      e.av = sum / 4;
      e.jt = (longint'(e.mx - e.mn) * 100 * (1 << FRAC_W)) / e.av;
      if (e.jt > JIT_MAX) e.jt = JIT_MAX;
      if (skipWindows > 0) skipWindows--;
      else if (!sat) expQ.push_back(e);
      winBuf.delete();
    end
    h = p / 2;
    pulseIn = 1'b0;
    repeat (p - h) @(negedge clk);
    pulseIn = 1'b1;
    repeat (h) @(negedge clk);
  endtask

  // Monitor: compare each strobe with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && resultValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(int'(maxPeriod) == e.mx, "R3 max", maxPeriod, e.mx);
        check(int'(minPeriod) == e.mn, "R3 min", minPeriod, e.mn);
        check(int'(avgPeriod) == e.av, "R4 avg", avgPeriod, e.av);
        check(longint'(jitterPct) == e.jt, "R5 jitter", jitterPct, e.jt);
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    check(resultValid == 1'b0, "R11 valid", resultValid, 0);
    check(maxPeriod == '0 && jitterPct == '0, "R11 outputs", maxPeriod, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1, R2: first call arms; equal periods give zero jitter
    repeat (4) sendPeriod(16);
    sendPeriod(13); sendPeriod(14); sendPeriod(15); sendPeriod(17); // R4 truncation
    sendPeriod(12); sendPeriod(40); sendPeriod(25); sendPeriod(33);
    sendPeriod(12); sendPeriod(12); sendPeriod(12); sendPeriod(1000); // R5 clamp

    // R10: short window closes while the previous division runs
    repeat (4) sendPeriod(20);
    skipWindows = 1;
    repeat (4) sendPeriod(4);
    repeat (4) sendPeriod(30);

    // R7: saturated period drops its window
    sendPeriod(12); sendPeriod(1100); sendPeriod(12); sendPeriod(12);
    sendPeriod(50); sendPeriod(18); sendPeriod(22); sendPeriod(26);

    // R8: clear mid-window
    sendPeriod(20); sendPeriod(20); sendPeriod(80);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    winBuf.delete();
    sendPeriod(24); sendPeriod(28); sendPeriod(20); sendPeriod(36);
    sendPeriod(24); sendPeriod(24); sendPeriod(80);

    // R9: edges while disabled are ignored
    enable = 1'b0;
    repeat (3) begin
      pulseIn = 1'b0; repeat (7) @(negedge clk);
      pulseIn = 1'b1; repeat (7) @(negedge clk);
    end
    enable = 1'b1;
    winBuf.delete();
    @(negedge clk);
    sendPeriod(18); sendPeriod(19); sendPeriod(20); sendPeriod(21);

    // closing edge and drain
    sendPeriod(40);
    repeat (100) @(negedge clk);
    check(expQ.size() == 0, "R2 all results seen", expQ.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule